// File: doc/BRIEF.md
# Read Latency and Burst Scheduler for a Synchronous Memory Device

This block tracks the command-to-data timing of a synchronous memory device. A configuration word, written by a load command, selects the read latency (two or three clocks), the burst length, the operating mode and whether writes are single-beat. Each read command produces a window in which the data pins are driven and a run of data-valid beats. The drive window opens one clock ahead of the first beat and closes one clock after the last beat. Each write command is acknowledged with the number of beats it will accept.

Reads may arrive while earlier bursts are still pending. Their beats are queued behind the earlier ones, so a stream of reads gives a continuous run of valid beats. The configuration word can only change while nothing is in flight. A load that arrives while a burst is in progress is dropped and reported.

Top module: `sdr_lat_ctrl`

## Requirements
- R1: While reset is asserted, and after reset, all outputs are low and the configuration is latency 3, burst length 1, normal mode, burst writes, sequential ordering. The bench sees this as a read with latency 3 and one beat.
- R2: The latency field is mode_word[6:4]: 010 selects 2 clocks and 011 selects 3 clocks. Any other value raises lat_err and gives latency 3.
- R3: A read registered at edge n, with latency m and burst length L, makes dq_valid high after edges n+m through n+m+L-1, and low after edge n+m+L if nothing is queued.
- R4: dq_oe goes high after edge n+m-1, one cycle before the first valid beat. It stays high through every valid beat and the cycle after the last one, and drops when no beat is pending in the cycle before or after.
- R5: The burst length field is mode_word[2:0]: 000=1, 001=2, 010=4, 011=8. Codes 100 to 111 raise bl_err and give length 1.
- R6: Reads follow each other without gaps. The beats of a read that arrives before the earlier beats have drained start right after them. A read registered L cycles after the previous one continues the run with no gap.
- R7: A nonzero value in mode_word[8:7] raises opmode_err. Read timing is unaffected.
- R8: A write registered at edge n makes wr_ack high after edge n, for one cycle, with wr_beats equal to the burst length when mode_word[9]=0, and equal to 1 when mode_word[9]=1.
- R9: A load is accepted only while busy is low. A load that arrives while busy is high leaves the configuration unchanged, and load_rej goes high after that edge.
- R10: cfg_interleave reports mode_word[3] of the accepted configuration.
- Commands are cmd_op 00 idle, 01 read, 10 write, 11 load, and act only with cmd_vld high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| mode_word | input | 10 | Configuration word, taken on a load command |
| dq_oe | output | 1 | Data pin drive enable |
| dq_valid | output | 1 | Read data beat valid |
| wr_ack | output | 1 | One-cycle write acknowledge |
| wr_beats | output | 4 | Beats the acknowledged write will accept |
| busy | output | 1 | A read or write burst is in flight |
| load_rej | output | 1 | A load was dropped because busy was high |
| lat_err | output | 1 | Latency field holds a reserved code |
| bl_err | output | 1 | Burst length field holds a reserved code |
| opmode_err | output | 1 | Operating mode field is not normal |
| cfg_interleave | output | 1 | Burst ordering bit of the configuration |

## Verification
The properties assume that cmd_op carries one command at a time, and that reads never arrive fast enough to overflow the pending-beat counter. The bench keeps to both. It issues at most two reads per window, and it waits until busy has cleared before it loads a new configuration, except when it tests rejection on purpose. The bench sweeps every legal latency and burst-length pair under both write modes, and every reserved code of each field. It also covers queued, abutting and gapped read pairs. Expected beat and drive windows are computed from the command cycle.

// File: rtl/sdr_lat_pkg.sv
`timescale 1ns/1ps
package sdr_lat_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_LOAD  = 2'b11
  } cmd_e;

  // field placement is decoded by the scheduler; keep the order
  typedef struct packed {
    logic       wr_single;   // [9]
    logic [1:0] opmode;      // [8:7]
    logic [2:0] lat_code;    // [6:4]
    logic       interleave;  // [3]
    logic [2:0] bl_code;     // [2:0]
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
  localparam int BL_MAX = 8;
  localparam int BEAT_W = $clog2(BL_MAX + 1);

  localparam mode_t MODE_RST = '{
    wr_single:  1'b0,
    opmode:     2'b00,
    lat_code:   3'b011,
    interleave: 1'b0,
    bl_code:    3'b000
  };

  function automatic logic lat_ok(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic bl_ok(input logic [2:0] code);
    return !code[2];
  endfunction

  function automatic logic [BEAT_W-1:0] bl_len(input logic [2:0] code);
    logic [BEAT_W-1:0] len;
    if (code[2]) len = BEAT_W'(1);
    else         len = BEAT_W'(1) << code[1:0];
    return len;
  endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
`timescale 1ns/1ps
module sdr_mode_reg
  import sdr_lat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic              busy,
  input  mode_t             word,
  output mode_t             mode_q,
  output logic              load_rej,
  output logic              lat3,
  output logic [BEAT_W-1:0] rd_len,
  output logic [BEAT_W-1:0] wr_len,
  output logic              lat_err,
  output logic              bl_err,
  output logic              opmode_err
);

  logic  take;
  logic  rej_d;
  mode_t mode_d;

  always_comb begin
    take   = load_req && !busy;
    rej_d  = load_req && busy;
    mode_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      load_rej <= 1'b0;
    end else begin
      if (take) mode_q <= mode_d;
      load_rej <= rej_d;
    end
  end

  always_comb begin
    lat_err    = !lat_ok(mode_q.lat_code);
    lat3       = lat_err || mode_q.lat_code[0];
    bl_err     = !bl_ok(mode_q.bl_code);
    rd_len     = bl_len(mode_q.bl_code);
    wr_len     = mode_q.wr_single ? BEAT_W'(1) : rd_len;
    opmode_err = |mode_q.opmode;
  end

endmodule

// File: rtl/sdr_rd_sched.sv
`timescale 1ns/1ps
module sdr_rd_sched
  import sdr_lat_pkg::*;
#(
  parameter int LAT_MAX = 3,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              lat3,
  input  logic [BEAT_W-1:0] rd_len,
  output logic              dq_oe,
  output logic              dq_valid,
  output logic              active
);

  localparam int IDX_W = $clog2(LAT_MAX);

  logic [LAT_MAX-1:0]             stg_v;
  logic [LAT_MAX-1:0][BEAT_W-1:0] stg_len;

  // one stage per clock of latency; stage k holds a read k+1 edges old
  for (genvar g = 0; g < LAT_MAX; g++) begin : g_stg
    logic              v_d;
    logic [BEAT_W-1:0] len_d;
    logic              v_q;
    logic [BEAT_W-1:0] len_q;

    if (g == 0) begin : g_head
      assign v_d   = rd_req;
      assign len_d = rd_len;
    end else begin : g_body
      assign v_d   = stg_v[g-1];
      assign len_d = stg_len[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        len_q <= '0;
      end else begin
        v_q <= v_d;
        if (v_d) len_q <= len_d;
      end
    end

    assign stg_v[g]   = v_q;
    assign stg_len[g] = len_q;
  end

  logic [IDX_W-1:0] arr_idx;
  logic [IDX_W-1:0] pre_idx;
  logic             arrive;
  logic             pre_arr;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic [CNT_W-1:0] total;
  logic             valid_d;
  logic             oe_d;

  always_comb begin
    arr_idx = lat3 ? IDX_W'(2) : IDX_W'(1);
    pre_idx = arr_idx - 1'b1;
    arrive  = stg_v[arr_idx];
    pre_arr = stg_v[pre_idx];
    total   = rem_q + (arrive ? CNT_W'(stg_len[arr_idx]) : '0);
    valid_d = (total != '0);
    rem_d   = valid_d ? (total - 1'b1) : '0;
    oe_d    = pre_arr || valid_d || dq_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      dq_valid <= 1'b0;
      dq_oe    <= 1'b0;
    end else begin
      rem_q    <= rem_d;
      dq_valid <= valid_d;
      dq_oe    <= oe_d;
    end
  end

  assign active = (|stg_v) || (rem_q != '0) || dq_oe;

endmodule

// File: rtl/sdr_wr_track.sv
`timescale 1ns/1ps
module sdr_wr_track
  import sdr_lat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [BEAT_W-1:0] wr_len,
  output logic              wr_ack,
  output logic [BEAT_W-1:0] wr_beats,
  output logic              active
);

  logic [BEAT_W-1:0] left_q;
  logic [BEAT_W-1:0] left_d;

  always_comb begin
    if (wr_req)              left_d = wr_len - 1'b1;
    else if (left_q != '0)   left_d = left_q - 1'b1;
    else                     left_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      wr_ack   <= 1'b0;
      wr_beats <= '0;
    end else begin
      left_q <= left_d;
      wr_ack <= wr_req;
      if (wr_req) wr_beats <= wr_len;
    end
  end

  assign active = (left_q != '0);

endmodule

// File: rtl/sdr_lat_ctrl.sv
`timescale 1ns/1ps
module sdr_lat_ctrl
  import sdr_lat_pkg::*;
#(
  parameter int LAT_MAX = 3,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [MODE_W-1:0] mode_word,
  output logic              dq_oe,
  output logic              dq_valid,
  output logic              wr_ack,
  output logic [BEAT_W-1:0] wr_beats,
  output logic              busy,
  output logic              load_rej,
  output logic              lat_err,
  output logic              bl_err,
  output logic              opmode_err,
  output logic              cfg_interleave
);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cmd_e op;
  logic rd_req, wr_req, ld_req;

  always_comb begin
    op     = cmd_e'(cmd_op);
    rd_req = cmd_vld && (op == CMD_READ);
    wr_req = cmd_vld && (op == CMD_WRITE);
    ld_req = cmd_vld && (op == CMD_LOAD);
  end

  mode_t             mode_q;
  logic              lat3;
  logic [BEAT_W-1:0] rd_len;
  logic [BEAT_W-1:0] wr_len;
  logic              rd_active;
  logic              wr_active;

  sdr_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_req   (ld_req),
    .busy       (busy),
    .word       (mode_t'(mode_word)),
    .mode_q     (mode_q),
    .load_rej   (load_rej),
    .lat3       (lat3),
    .rd_len     (rd_len),
    .wr_len     (wr_len),
    .lat_err    (lat_err),
    .bl_err     (bl_err),
    .opmode_err (opmode_err)
  );

  sdr_rd_sched #(
    .LAT_MAX (LAT_MAX),
    .CNT_W   (CNT_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_req   (rd_req),
    .lat3     (lat3),
    .rd_len   (rd_len),
    .dq_oe    (dq_oe),
    .dq_valid (dq_valid),
    .active   (rd_active)
  );

  sdr_wr_track u_wr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_req   (wr_req),
    .wr_len   (wr_len),
    .wr_ack   (wr_ack),
    .wr_beats (wr_beats),
    .active   (wr_active)
  );

  assign busy           = rd_active || wr_active;
  assign cfg_interleave = mode_q.interleave;

endmodule

// File: rtl/sdr_lat_ctrl_chk.sv
`timescale 1ns/1ps
module sdr_lat_ctrl_chk
  import sdr_lat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_vld,
  input logic [1:0]        cmd_op,
  input logic              dq_oe,
  input logic              dq_valid,
  input logic              wr_ack,
  input logic [BEAT_W-1:0] wr_beats,
  input logic              load_rej,
  input logic              lat_err,
  input logic              lat3,
  input mode_t             mode_q
);

  logic rd_cmd;
  assign rd_cmd = cmd_vld && (cmd_op == 2'b01);

  p_valid_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> dq_oe);

  p_drive_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid) |-> $past(dq_oe));

  p_drive_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_valid) |-> dq_oe);

  p_lat2_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !lat3) |=> ##1 dq_oe);

  p_lat3_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && lat3) |=> ##2 dq_oe);

  p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_rej |-> $stable(mode_q));

  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && mode_q.wr_single) |-> (wr_beats == BEAT_W'(1)));

  p_lat_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lat_err |-> lat3);

endmodule

bind sdr_lat_ctrl sdr_lat_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .cmd_vld  (cmd_vld),
  .cmd_op   (cmd_op),
  .dq_oe    (dq_oe),
  .dq_valid (dq_valid),
  .wr_ack   (wr_ack),
  .wr_beats (wr_beats),
  .load_rej (load_rej),
  .lat_err  (lat_err),
  .lat3     (lat3),
  .mode_q   (mode_q)
);

// File: tb/sdr_lat_ctrl_tb.sv
`timescale 1ns/1ps
module sdr_lat_ctrl_tb;
  import sdr_lat_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld;
  logic [1:0]  cmd_op;
  logic [9:0]  mode_word;
  logic        dq_oe, dq_valid, wr_ack, busy, load_rej;
  logic        lat_err, bl_err, opmode_err, cfg_interleave;
  logic [3:0]  wr_beats;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sdr_lat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .mode_word(mode_word), .dq_oe(dq_oe), .dq_valid(dq_valid),
    .wr_ack(wr_ack), .wr_beats(wr_beats), .busy(busy), .load_rej(load_rej),
    .lat_err(lat_err), .bl_err(bl_err), .opmode_err(opmode_err),
    .cfg_interleave(cfg_interleave)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input int wb, input int opm, input int lat,
                                    input int il, input int bl);
    return {wb[0], opm[1:0], lat[2:0], il[0], bl[2:0]};
  endfunction

  // called at a negedge; returns at the negedge after the command edge
  task automatic send(input logic [1:0] op, input logic [9:0] w);
    cmd_vld = 1'b1; cmd_op = op; mode_word = w;
    @(posedge clk); @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit vexp(input int k, input int m, input int bl,
                              input int g, input int s2);
    bit a, b;
    a = (k >= m) && (k <= m + bl - 1);
    b = (g > 0) && (k >= s2) && (k <= s2 + bl - 1);
    return a || b;
  endfunction

  // first read at edge n; optional second read at edge n+g
  task automatic run_rd(input int m, input int bl, input int g, input string req);
    int e1, s2, e2, bad_v, bad_o, first_k;
    bit ev, eo;
    e1 = m + bl - 1;
    s2 = 0;
    e2 = e1;
    if (g > 0) begin
      s2 = (g + m > e1 + 1) ? g + m : e1 + 1;
      e2 = s2 + bl - 1;
    end
    bad_v = 0; bad_o = 0; first_k = -1;
    cmd_vld = 1'b1; cmd_op = 2'b01;
    @(posedge clk); @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 2'b00;
    for (int k = 1; k <= e2 + 2; k++) begin
      if (k == g) begin cmd_vld = 1'b1; cmd_op = 2'b01; end
      @(posedge clk); @(negedge clk);
      cmd_vld = 1'b0; cmd_op = 2'b00;
      ev = vexp(k, m, bl, g, s2);
      eo = vexp(k-1, m, bl, g, s2) || ev || vexp(k+1, m, bl, g, s2);
      if (dq_valid !== ev) begin bad_v++; if (first_k < 0) first_k = k; end
      if (dq_oe !== eo)    begin bad_o++; if (first_k < 0) first_k = k; end
    end
    check(bad_v == 0, req, $sformatf("valid window m=%0d bl=%0d g=%0d mismatch cycles", m, bl, g), bad_v, 0);
    check(bad_o == 0, "R4", $sformatf("drive window m=%0d bl=%0d g=%0d mismatch cycles", m, bl, g), bad_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_op = 2'b00; mode_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check({dq_oe, dq_valid, wr_ack, busy, load_rej, lat_err, bl_err, opmode_err, cfg_interleave} == 0,
          "R1", "outputs in reset", int'({dq_oe, dq_valid, wr_ack, busy, load_rej}), 0);
    rst_n = 1'b1;
    gap(4);
    check({dq_oe, dq_valid, wr_ack, busy, load_rej, lat_err, bl_err, opmode_err} == 0,
          "R1", "outputs after reset", int'({dq_oe, dq_valid, wr_ack, busy}), 0);
    // R1: default configuration is latency 3, one beat
    run_rd(3, 1, 0, "R1");
    send(2'b10, '0);
    check(wr_ack && wr_beats == 1, "R1", "default write beats", wr_beats, 1);
    gap(3);

    // sweep legal latency x burst length x write mode (R3, R5, R8)
    for (int wb = 0; wb < 2; wb++)
      for (int lat = 2; lat <= 3; lat++)
        for (int blc = 0; blc < 4; blc++) begin
          send(2'b11, mk(wb, 0, (lat == 2) ? 3'b010 : 3'b011, 0, blc));
          check(!lat_err && !bl_err && !load_rej, "R2", "legal code flags", int'({lat_err, bl_err, load_rej}), 0);
          run_rd(lat, 1 << blc, 0, "R3");
          send(2'b10, '0);
          check(wr_ack == 1'b1, "R8", "write ack", wr_ack, 1);
          check(wr_beats == ((wb != 0) ? 1 : (1 << blc)), "R8", "write beats",
                wr_beats, (wb != 0) ? 1 : (1 << blc));
          gap(1);
          check(wr_ack == 1'b0, "R8", "write ack one cycle", wr_ack, 0);
          gap(10);
        end

    // R6: queued, abutting and gapped read pairs
    send(2'b11, mk(0, 0, 3'b010, 0, 2));
    run_rd(2, 4, 4, "R6");
    run_rd(2, 4, 1, "R6");
    send(2'b11, mk(0, 0, 3'b011, 0, 3));
    run_rd(3, 8, 8, "R6");
    run_rd(3, 8, 2, "R6");
    send(2'b11, mk(0, 0, 3'b011, 0, 1));
    run_rd(3, 2, 5, "R6");

    // R2: reserved latency codes give latency 3
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 3) continue;
      send(2'b11, mk(0, 0, c, 0, 1));
      check(lat_err == 1'b1, "R2", $sformatf("lat_err for code %0d", c), lat_err, 1);
      run_rd(3, 2, 0, "R2");
    end

    // R5: reserved burst codes give one beat
    for (int c = 4; c < 8; c++) begin
      send(2'b11, mk(0, 0, 3'b010, 0, c));
      check(bl_err == 1'b1 && !lat_err, "R5", $sformatf("bl_err for code %0d", c), bl_err, 1);
      run_rd(2, 1, 0, "R5");
      send(2'b10, '0);
      check(wr_beats == 1, "R5", "write beats for reserved length", wr_beats, 1);
      gap(3);
    end

    // R7: non-normal operating mode flagged, timing unchanged
    for (int o = 1; o < 4; o++) begin
      send(2'b11, mk(0, o, 3'b010, 0, 2));
      check(opmode_err == 1'b1, "R7", $sformatf("opmode_err for %0d", o), opmode_err, 1);
      run_rd(2, 4, 0, "R7");
    end
    send(2'b11, mk(0, 0, 3'b010, 0, 2));
    check(opmode_err == 1'b0, "R7", "opmode_err clears", opmode_err, 0);

    // R10: ordering bit reported
    send(2'b11, mk(0, 0, 3'b011, 1, 0));
    check(cfg_interleave == 1'b1, "R10", "ordering bit set", cfg_interleave, 1);
    send(2'b11, mk(0, 0, 3'b011, 0, 0));
    check(cfg_interleave == 1'b0, "R10", "ordering bit clear", cfg_interleave, 0);

    // R9: load during a read burst is dropped
    send(2'b11, mk(0, 0, 3'b010, 0, 3));
    check(load_rej == 1'b0, "R9", "idle load accepted", load_rej, 0);
    send(2'b01, '0);
    check(busy == 1'b1, "R9", "busy after read", busy, 1);
    send(2'b11, mk(1, 0, 3'b011, 1, 0));
    check(load_rej == 1'b1, "R9", "load during read rejected", load_rej, 1);
    check(cfg_interleave == 1'b0, "R9", "config kept after reject", cfg_interleave, 0);
    gap(1);
    check(load_rej == 1'b0, "R9", "reject pulse ends", load_rej, 0);
    gap(15);
    run_rd(2, 8, 0, "R9");
    // R9: load during a write burst is dropped
    send(2'b10, '0);
    send(2'b11, mk(1, 0, 3'b011, 1, 0));
    check(load_rej == 1'b1, "R9", "load during write rejected", load_rej, 1);
    gap(10);
    send(2'b10, '0);
    check(wr_beats == 8, "R9", "write length kept after reject", wr_beats, 8);
    gap(10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule